// File: doc/BRIEF.md
# Card Interface Power-Down Sequencer

This block is the control state machine that sits between a host controller and the analog front end of a smart card interface. It decides when the analog circuitry may be put into a low-power state, how long the interface must wait after waking up before it is usable, and when a card session may begin or must end.

The host drives four inputs: a power-down request, an active-low session command, a card-presence signal and an over-temperature flag. All four are asynchronous and pass through two flip-flops before use. A session opens only on a high-to-low edge of the synchronized session command. Edges that arrive while powered down or during the recovery wait are dropped, so after waking the host must raise the command and lower it again.

A session ends when the command rises, when the card is removed or when the die overheats. Each of these runs a timed deactivation phase. Over-temperature also raises a sticky fault flag. The recovery wait and the deactivation phase are parameters counted in clock cycles.

Top module: `card_pwr_seq`

## Requirements
- R1: When the synchronized power-down request is high and the synchronized session command is high while the block is idle or recovering, the block enters power-down and `analog_pd_o` goes high. This happens on the third rising edge after the inputs change.
- R2: A power-down request has no effect while a session is active or a deactivation is running. `analog_pd_o` stays low and the session stays active.
- R3: When the request is released during power-down, `analog_pd_o` falls in the same cycle the recovery wait begins. The wait lasts exactly `STAB_CYC` cycles and then the block is idle.
- R4: A session starts (`sess_active_o` high) only on a high-to-low edge of the synchronized session command taken in the idle state, with a card present and no over-temperature. A command that is already low when idle is reached starts nothing.
- R5: Falling edges of the session command that arrive during power-down or during the recovery wait are discarded and never start a session later.
- R6: `status_o` equals the synchronized card-presence input in every state except the recovery wait, where it is low. With a card present it therefore rises when recovery ends. It tracks the card during power-down.
- R7: Over-temperature during a session moves the block to deactivation on the next state update and sets `fault_o`.
- R8: Deactivation holds `deact_busy_o` high for exactly `DEACT_CYC` cycles and then returns to idle.
- R9: Once set by over-temperature in any state, `fault_o` stays high until the next valid session start, which clears it. No session starts while over-temperature is high.
- R10: During a session, a rising edge of the session command or the loss of card presence starts deactivation.
- R11: After reset the block is idle and `status_o`, `analog_pd_o`, `sess_active_o`, `deact_busy_o` and `fault_o` are all low.
- R12: A change on the card-presence input reaches `status_o` on the second rising edge, through the two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_dn_req_i | input | 1 | Power-down request, active high, asynchronous |
| sess_cmd_n_i | input | 1 | Session command, active low, asynchronous |
| card_in_i | input | 1 | Card presence, active high, asynchronous |
| over_temp_i | input | 1 | Over-temperature flag, active high, asynchronous |
| status_o | output | 1 | Card presence / recovery-complete indication to the host |
| analog_pd_o | output | 1 | Power-down enable for the analog blocks |
| sess_active_o | output | 1 | A card session is active |
| deact_busy_o | output | 1 | A deactivation sequence is in progress |
| fault_o | output | 1 | Sticky over-temperature fault |

## Verification
The bench targets a few specific failure modes.

- It lowers the session command while powered down, and again during the recovery wait. A design that latched such an edge, or that started on a low level, would open a session once idle.
- It holds a power-down request through a live session. A design that did not gate the request would drop the analog supply under a card.
- It keeps over-temperature high across a start attempt and then releases it. This shows that the fault flag stays high until a real start clears it.
- It counts the recovery and deactivation windows cycle by cycle. An off-by-one counter shows up as a mismatch at the window edges.

// File: rtl/card_pwr_pkg.sv
package card_pwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PDN   = 3'd1,
        ST_STAB  = 3'd2,
        ST_ACT   = 3'd3,
        ST_DEACT = 3'd4
    } seq_state_e;

    // synchronized host-side controls
    typedef struct packed {
        logic pd_req;
        logic cmd_n;
        logic card;
        logic hot;
    } ctl_in_t;

    localparam int CTL_W = $bits(ctl_in_t);
    localparam ctl_in_t CTL_IDLE = '{pd_req: 1'b0, cmd_n: 1'b1, card: 1'b0, hot: 1'b0};

    function automatic int cnt_width(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return $clog2(m + 1) + 1;
    endfunction

endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cps_edge.sv
module cps_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic fall,
    output logic rise
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= lvl;
    end

    assign fall = prev & ~lvl;
    assign rise = ~prev & lvl;
endmodule

// File: rtl/cps_timer.sv
module cps_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/cps_fsm.sv
module cps_fsm
    import card_pwr_pkg::*;
#(
    parameter int STAB_CYC  = 16,
    parameter int DEACT_CYC = 8,
    parameter int CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_in_t          ctl,
    input  logic             cmd_fall,
    input  logic             cmd_rise,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output seq_state_e       state,
    output logic             fault
);
    localparam logic [CNT_W-1:0] STAB_LOAD  = CNT_W'(STAB_CYC - 1);
    localparam logic [CNT_W-1:0] DEACT_LOAD = CNT_W'(DEACT_CYC - 1);

    seq_state_e nxt;
    logic       pd_ok;
    logic       start;

    assign pd_ok = ctl.pd_req & ctl.cmd_n;

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = STAB_LOAD;
        start    = 1'b0;
        case (state)
            ST_IDLE: begin
                if (pd_ok) begin
                    nxt = ST_PDN;
                end else if (cmd_fall && ctl.card && !ctl.hot) begin
                    nxt   = ST_ACT;
                    start = 1'b1;
                end
            end
            ST_PDN: begin
                if (!ctl.pd_req) begin
                    nxt      = ST_STAB;
                    tmr_load = 1'b1;
                    tmr_val  = STAB_LOAD;
                end
            end
            ST_STAB: begin
                if (pd_ok)         nxt = ST_PDN;
                else if (tmr_done) nxt = ST_IDLE;
            end
            ST_ACT: begin
                if (ctl.hot || cmd_rise || !ctl.card) begin
                    nxt      = ST_DEACT;
                    tmr_load = 1'b1;
                    tmr_val  = DEACT_LOAD;
                end
            end
            ST_DEACT: begin
                if (tmr_done) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            fault <= 1'b0;
        end else begin
            state <= nxt;
            if (ctl.hot)    fault <= 1'b1;
            else if (start) fault <= 1'b0;
        end
    end
endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq
    import card_pwr_pkg::*;
#(
    parameter int STAB_CYC    = 500000,
    parameter int DEACT_CYC   = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_dn_req_i,
    input  logic sess_cmd_n_i,
    input  logic card_in_i,
    input  logic over_temp_i,
    output logic status_o,
    output logic analog_pd_o,
    output logic sess_active_o,
    output logic deact_busy_o,
    output logic fault_o
);
    localparam int CNT_W = cnt_width(STAB_CYC, DEACT_CYC);

    ctl_in_t          raw_in;
    ctl_in_t          s_in;
    logic [CTL_W-1:0] s_vec;
    logic             cmd_fall;
    logic             cmd_rise;
    logic             tmr_load;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_val;
    seq_state_e       state;
    logic             fault;

    assign raw_in = '{pd_req: pwr_dn_req_i, cmd_n: sess_cmd_n_i,
                      card: card_in_i, hot: over_temp_i};

    cps_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(s_vec)
    );
    assign s_in = ctl_in_t'(s_vec);

    cps_edge u_edge (
        .clk(clk), .rst(rst), .lvl(s_in.cmd_n), .fall(cmd_fall), .rise(cmd_rise)
    );

    cps_timer #(.W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    cps_fsm #(.STAB_CYC(STAB_CYC), .DEACT_CYC(DEACT_CYC), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst), .ctl(s_in), .cmd_fall(cmd_fall), .cmd_rise(cmd_rise),
        .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .state(state), .fault(fault)
    );

    assign status_o      = s_in.card & (state != ST_STAB);
    assign analog_pd_o   = (state == ST_PDN);
    assign sess_active_o = (state == ST_ACT);
    assign deact_busy_o  = (state == ST_DEACT);
    assign fault_o       = fault;
endmodule

// File: rtl/cps_checker.sv
module cps_checker (
    input logic clk,
    input logic rst,
    input logic status_o,
    input logic analog_pd_o,
    input logic sess_active_o,
    input logic deact_busy_o,
    input logic fault_o
);
    // R2: a live session is never followed by power-down
    assert_no_pd_in_session_R2: assert property (@(posedge clk) disable iff (rst)
        sess_active_o |=> !analog_pd_o);

    // R3: leaving power-down enters the recovery wait, where status is low
    assert_status_low_on_wake_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(analog_pd_o) |-> !status_o);

    // R4: a session opens only from idle, never straight out of power-down
    assert_start_from_idle_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sess_active_o) |-> !$past(analog_pd_o) && !$past(deact_busy_o));

    // R9: a valid start clears the fault flag
    assert_start_clears_fault_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sess_active_o) |-> !fault_o);

    // R10: a session always ends through deactivation
    assert_end_via_deact_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(sess_active_o) |-> deact_busy_o);

    // R8: deactivation never hands back directly to a session
    assert_deact_to_idle_R8: assert property (@(posedge clk) disable iff (rst)
        deact_busy_o |=> !sess_active_o);

    // R1: outputs for distinct states never overlap
    assert_state_outputs_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        $countones({analog_pd_o, sess_active_o, deact_busy_o}) <= 1);
endmodule

bind card_pwr_seq cps_checker u_cps_chk (
    .clk(clk), .rst(rst), .status_o(status_o), .analog_pd_o(analog_pd_o),
    .sess_active_o(sess_active_o), .deact_busy_o(deact_busy_o), .fault_o(fault_o)
);

// File: tb/card_pwr_seq_bench.sv
module card_pwr_seq_bench;
    localparam int STAB  = 20;
    localparam int DEACT = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd = 1'b0, cmd = 1'b1, card = 1'b0, hot = 1'b0;
    logic status_o, analog_pd_o, sess_active_o, deact_busy_o, fault_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit cmp_en = 1'b0;

    always #2 clk = ~clk;

    card_pwr_seq #(.STAB_CYC(STAB), .DEACT_CYC(DEACT)) u_card_pwr_seq (
        .clk(clk), .rst(rst), .pwr_dn_req_i(pd), .sess_cmd_n_i(cmd),
        .card_in_i(card), .over_temp_i(hot), .status_o(status_o),
        .analog_pd_o(analog_pd_o), .sess_active_o(sess_active_o),
        .deact_busy_o(deact_busy_o), .fault_o(fault_o)
    );

    // ---------------- behavioural reference model ----------------
    // mode: 0 idle, 1 power-down, 2 recovering, 3 session, 4 deactivating
    logic pipe_pd[$], pipe_cmd[$], pipe_card[$], pipe_hot[$];
    int   m_mode, m_left;
    bit   m_fault, m_prev_cmd;
    bit   e_status, e_pd, e_act, e_deact;

    function automatic void model_outputs();
        e_status = pipe_card[0] && (m_mode != 2);
        e_pd     = (m_mode == 1);
        e_act    = (m_mode == 3);
        e_deact  = (m_mode == 4);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            pipe_pd = '{0, 0};  pipe_cmd = '{1, 1};
            pipe_card = '{0, 0}; pipe_hot = '{0, 0};
            m_mode = 0; m_left = 0; m_fault = 0; m_prev_cmd = 1;
        end else begin
            bit sp, sc, sk, sh, fe, re, go;
            sp = pipe_pd[0]; sc = pipe_cmd[0]; sk = pipe_card[0]; sh = pipe_hot[0];
            fe = m_prev_cmd && !sc;
            re = !m_prev_cmd && sc;
            go = 0;
            case (m_mode)
                0: if (sp && sc) m_mode = 1;
                   else if (fe && sk && !sh) begin m_mode = 3; go = 1; end
                1: if (!sp) begin m_mode = 2; m_left = STAB - 1; end
                2: if (sp && sc) m_mode = 1;
                   else if (m_left == 0) m_mode = 0;
                   else m_left--;
                3: if (sh || re || !sk) begin m_mode = 4; m_left = DEACT - 1; end
                4: if (m_left == 0) m_mode = 0; else m_left--;
                default: m_mode = 0;
            endcase
            if (m_mode == 1 || m_mode == 0 || m_mode == 3) begin
                // timer only runs in the timed modes
            end
            if (sh) m_fault = 1; else if (go) m_fault = 0;
            m_prev_cmd = sc;
            void'(pipe_pd.pop_front());   pipe_pd.push_back(pd);
            void'(pipe_cmd.pop_front());  pipe_cmd.push_back(cmd);
            void'(pipe_card.pop_front()); pipe_card.push_back(card);
            void'(pipe_hot.pop_front());  pipe_hot.push_back(hot);
        end
        model_outputs();
    end

    task automatic cmp(input logic act, input bit exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            cmp(status_o,      e_status,  "R6",  "status");
            cmp(analog_pd_o,   e_pd,      "R1",  "analog_pd");
            cmp(sess_active_o, e_act,     "R4",  "sess_active");
            cmp(deact_busy_o,  e_deact,   "R8",  "deact_busy");
            cmp(fault_o,       m_fault,   "R9",  "fault");
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic act, input bit exp, input string req, input string what);
        cmp(act, exp, req, what);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        step(5);
        rst = 1'b0;
        step(1);
        cmp_en = 1'b1;
        // R11 reset state
        chk(status_o, 0, "R11", "status after reset");
        chk(analog_pd_o, 0, "R11", "analog_pd after reset");
        chk(sess_active_o, 0, "R11", "active after reset");
        chk(deact_busy_o, 0, "R11", "deact after reset");
        chk(fault_o, 0, "R11", "fault after reset");
        // R12 synchronizer latency on card presence
        card = 1'b1;
        step(1); chk(status_o, 0, "R12", "status after one edge");
        step(1); chk(status_o, 1, "R12", "status after two edges");
        step(3);
        // R4 start on falling edge
        cmd = 1'b0;
        step(2); chk(sess_active_o, 0, "R4", "active before third edge");
        step(1); chk(sess_active_o, 1, "R4", "active after third edge");
        step(5);
        // R2 power-down ignored during session
        pd = 1'b1; step(10);
        chk(analog_pd_o, 0, "R2", "pd during session");
        chk(sess_active_o, 1, "R2", "session kept");
        pd = 1'b0; step(3);
        // R10 rising command ends session
        cmd = 1'b1; step(5);
        chk(deact_busy_o, 1, "R10", "deact on rising cmd");
        step(DEACT + 2);
        chk(deact_busy_o, 0, "R8", "deact finished");
        chk(sess_active_o, 0, "R8", "idle after deact");
        // R1 power-down in idle
        pd = 1'b1; step(5);
        chk(analog_pd_o, 1, "R1", "pd entered");
        // R6 status follows card during power-down
        card = 1'b0; step(3); chk(status_o, 0, "R6", "card out in pd");
        card = 1'b1; step(3); chk(status_o, 1, "R6", "card in during pd");
        // R5 fall during power-down discarded
        cmd = 1'b0; step(5);
        chk(sess_active_o, 0, "R5", "fall in pd");
        // R3 wake up, recovery window
        pd = 1'b0; step(5);
        chk(analog_pd_o, 0, "R3", "pd released");
        chk(status_o, 0, "R3", "status low while recovering");
        step(STAB + 5);
        chk(status_o, 1, "R6", "status high after recovery");
        chk(sess_active_o, 0, "R4", "low level does not start");
        cmd = 1'b1; step(5); cmd = 1'b0; step(5);
        chk(sess_active_o, 1, "R4", "re-toggle starts");
        cmd = 1'b1; step(DEACT + 8);
        // R5 fall inside recovery window discarded
        pd = 1'b1; step(5); pd = 1'b0; step(5);
        cmd = 1'b0; step(STAB + 5);
        chk(sess_active_o, 0, "R5", "fall in recovery");
        cmd = 1'b1; step(5); cmd = 1'b0; step(5);
        chk(sess_active_o, 1, "R4", "start after recovery");
        // R7 over-temperature in session
        hot = 1'b1; step(4);
        chk(deact_busy_o, 1, "R7", "deact on over-temp");
        chk(fault_o, 1, "R7", "fault raised");
        step(DEACT + 4);
        // R9 blocked while hot, sticky after
        cmd = 1'b1; step(5); cmd = 1'b0; step(5);
        chk(sess_active_o, 0, "R9", "start blocked while hot");
        hot = 1'b0; step(5);
        chk(fault_o, 1, "R9", "fault sticky");
        cmd = 1'b1; step(5); cmd = 1'b0; step(5);
        chk(sess_active_o, 1, "R9", "start after cooling");
        chk(fault_o, 0, "R9", "fault cleared by start");
        // R10 card removal ends session
        card = 1'b0; step(4);
        chk(deact_busy_o, 1, "R10", "deact on card removal");
        step(DEACT + 4);
        // R9 over-temp in idle sets fault
        hot = 1'b1; step(4); hot = 1'b0; step(4);
        chk(fault_o, 1, "R9", "fault from idle over-temp");
        step(5);
        summary();
    end
endmodule